// File: doc/BRIEF.md
# XOR Swizzle Bank Address Unit

This unit takes a linear element address in a banked on-chip scratch memory and permutes it with a bit-group XOR swizzle. The element size and a swizzle-width selector set the swizzle. After the permutation the unit reports the 4-byte bank that holds the element and the 128-byte line it falls in. The swizzle leaves a low group of M address bits untouched. It takes a B-bit field that starts S bits above that group and folds it, by XOR, into the lowest B bits just above the group. Without the swizzle, a column walk down a row-major tile keeps hitting the same bank. With it, the walk is spread across banks.

A second path takes eight element addresses in one strobe, applies the same swizzle to each and returns the worst-case bank conflict degree. That degree is the largest number of distinct 4-byte words that the group needs from any single bank. An address generator can use it to judge whether a planned access pattern serialises. Both paths share the element-size code and the mode selector.

Top module: `swz_bank_unit`

## Requirements
- R1: The element-size code sets the unswizzled group width M. Code 0 is 1-byte elements with M=4, code 1 is 2-byte with M=3 and code 2 is 4-byte with M=2, so a 16-byte run stays in place. The mode code sets B: 0 for none, 1 for 32B, 2 for 64B and 3 for 128B. S is fixed at 3.
- R2: For a valid configuration, out_addr = a XOR ((((a >> (M+S)) AND (2^B − 1))) << M), where a is in_addr. In particular, the low M bits of out_addr always equal those of in_addr.
- R3: With mode code 0 (none), out_addr equals in_addr for every valid element size.
- R4: out_bank = floor(out_addr·bytes/4) mod 32 and out_line = floor(out_addr·bytes/128), where bytes is 1, 2 or 4 as set by the element-size code.
- R5: out_vld is high exactly two clock cycles after a cycle with in_vld high, and low two cycles after a cycle with in_vld low. out_addr, out_bank, out_line and out_err are valid with it.
- R6: Element-size code 3, or any B greater than S, sets out_err. In that case out_addr, out_bank and out_line are 0.
- R7: cnf_vld is high one cycle after grp_vld. cnf_degree is then the maximum, over the 32 banks, of the number of distinct 4-byte words the eight swizzled addresses touch in that bank. Repeated addresses within one word count once.
- R8: For an 8×64 tile of 2-byte elements (address 64·i + j), column 0 with mode 128B lands on banks 0, 4, 8, …, 28 and gives degree 1. With mode none, the same column gives degree 8.
- R9: While reset is held and just after it, out_vld and cnf_vld are 0 and all data outputs are 0.
- R10: An invalid configuration on the group path sets cnf_err and forces cnf_degree to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_dtype | input | 2 | Element-size code (0: 1 B, 1: 2 B, 2: 4 B, 3: invalid) |
| in_mode | input | 2 | Swizzle width (0 none, 1 32B, 2 64B, 3 128B) |
| in_vld | input | 1 | Single-address strobe |
| in_addr | input | ADDR_W | Linear element address |
| out_vld | output | 1 | Single-address result valid |
| out_addr | output | ADDR_W | Swizzled element address |
| out_bank | output | 5 | Bank index |
| out_line | output | ADDR_W-5 | 128-byte line index |
| out_err | output | 1 | Invalid configuration on the single path |
| grp_vld | input | 1 | Group strobe |
| grp_addr | input | 8·ADDR_W | Eight element addresses, lane k in bits [k·ADDR_W +: ADDR_W] |
| cnf_vld | output | 1 | Conflict result valid |
| cnf_degree | output | 4 | Worst-case distinct words in one bank |
| cnf_err | output | 1 | Invalid configuration on the group path |

## Verification
The single-address results go through two register stages and are due on the second clock edge after the strobe. The conflict degree has one register stage and is due on the first edge. The bench applies inputs on the falling edge. For the single path it checks one falling edge after the strobe that out_vld is still low, and one edge later it checks every single-path output. For the group path it checks one falling edge after the strobe. Each probe waits for its result to settle before the next strobe, so no result is read from a neighbouring stimulus.

// File: rtl/swz_pkg.sv
package swz_pkg;

  typedef enum logic [1:0] {
    MODE_NONE = 2'd0,
    MODE_W32  = 2'd1,
    MODE_W64  = 2'd2,
    MODE_W128 = 2'd3
  } swz_mode_e;

  typedef enum logic [1:0] {
    ESZ_1B   = 2'd0,
    ESZ_2B   = 2'd1,
    ESZ_4B   = 2'd2,
    ESZ_RSVD = 2'd3
  } elem_size_e;

  // decoded swizzle configuration
  typedef struct packed {
    logic [2:0] keep_w;   // low bits left untouched (M)
    logic [1:0] fold_w;   // folded field width (B)
    logic [1:0] byte_sh;  // log2 of element bytes
    logic       bad;      // configuration invalid
  } swz_cfg_t;

endpackage

// File: rtl/swz_param_decode.sv
module swz_param_decode
  import swz_pkg::*;
#(
  parameter int ATOM_LEN = 3
) (
  input  logic [1:0] esz_code,
  input  logic [1:0] mode_code,
  output swz_cfg_t   cfg
);

  elem_size_e esz;
  logic       size_bad;
  logic       fold_bad;

  assign esz = elem_size_e'(esz_code);

  always_comb begin
    cfg.keep_w  = 3'd0;
    cfg.byte_sh = 2'd0;
    size_bad    = 1'b0;
    case (esz)
      ESZ_1B: begin cfg.keep_w = 3'd4; cfg.byte_sh = 2'd0; end
      ESZ_2B: begin cfg.keep_w = 3'd3; cfg.byte_sh = 2'd1; end
      ESZ_4B: begin cfg.keep_w = 3'd2; cfg.byte_sh = 2'd2; end
      default: size_bad = 1'b1;
    endcase
    cfg.fold_w = mode_code;
    fold_bad   = (int'(mode_code) > ATOM_LEN);
    cfg.bad    = size_bad | fold_bad;
  end

endmodule

// File: rtl/swz_permute.sv
module swz_permute #(
  parameter int ADDR_W   = 16,
  parameter int ATOM_LEN = 3
) (
  input  logic [ADDR_W-1:0] lin_addr,
  input  logic [2:0]        keep_w,
  input  logic [1:0]        fold_w,
  output logic [ADDR_W-1:0] swz_addr
);

  localparam int SH_W = 6;

  logic [SH_W-1:0]   src_sh;
  logic [ADDR_W-1:0] fold_mask;
  logic [ADDR_W-1:0] fold_bits;

  always_comb begin
    src_sh    = SH_W'(keep_w) + SH_W'(ATOM_LEN);
    fold_mask = (ADDR_W'(1) << fold_w) - ADDR_W'(1);
    fold_bits = (lin_addr >> src_sh) & fold_mask;
    swz_addr  = lin_addr ^ (fold_bits << keep_w);
  end

endmodule

// File: rtl/swz_bank_calc.sv
module swz_bank_calc #(
  parameter int ADDR_W     = 16,
  parameter int BANK_BYTES = 4,
  parameter int NBANK      = 32,
  localparam int WORD_LSB  = $clog2(BANK_BYTES),
  localparam int BANK_W    = $clog2(NBANK),
  localparam int LINE_LSB  = WORD_LSB + BANK_W,
  localparam int BYTE_W    = ADDR_W + 2,
  localparam int LINE_W    = BYTE_W - LINE_LSB
) (
  input  logic [ADDR_W-1:0] elem_addr,
  input  logic [1:0]        byte_sh,
  output logic [BANK_W-1:0] bank,
  output logic [LINE_W-1:0] line
);

  logic [BYTE_W-1:0] byte_addr;

  always_comb begin
    byte_addr = {2'b00, elem_addr} << byte_sh;
    bank      = BANK_W'(byte_addr >> WORD_LSB);
    line      = LINE_W'(byte_addr >> LINE_LSB);
  end

endmodule

// File: rtl/swz_conflict_count.sv
module swz_conflict_count #(
  parameter int LANES    = 8,
  parameter int WORD_W   = 16,
  parameter int BANK_W   = 5,
  localparam int CNT_W   = $clog2(LANES + 1)
) (
  input  logic              clk,
  input  logic              rst_q,
  input  logic              req_vld,
  input  logic              req_bad,
  input  logic [WORD_W-1:0] word [LANES],
  output logic              res_vld,
  output logic [CNT_W-1:0]  res_degree,
  output logic              res_bad
);

  logic             first_use [LANES];
  logic [CNT_W-1:0] per_lane  [LANES];
  logic [CNT_W-1:0] worst;
  logic [CNT_W-1:0] degree_d;

  // a word counts once: only its first lane contributes
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      first_use[i] = 1'b1;
      for (int j = 0; j < i; j++) begin
        if (word[j] == word[i]) first_use[i] = 1'b0;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      per_lane[i] = '0;
      for (int j = 0; j < LANES; j++) begin
        if (first_use[j] && (word[j][BANK_W-1:0] == word[i][BANK_W-1:0]))
          per_lane[i] = per_lane[i] + CNT_W'(1);
      end
    end
    worst = '0;
    for (int i = 0; i < LANES; i++) begin
      if (per_lane[i] > worst) worst = per_lane[i];
    end
    degree_d = req_bad ? '0 : worst;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      res_vld <= 1'b0;
    end else begin
      res_vld <= req_vld;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      res_degree <= '0;
      res_bad    <= 1'b0;
    end else if (req_vld) begin
      res_degree <= degree_d;
      res_bad    <= req_bad;
    end
  end

  AST_DEG_BOUND: assert property (@(posedge clk) disable iff (!rst_q)
    (res_vld && !res_bad) |-> (res_degree >= CNT_W'(1) && res_degree <= CNT_W'(LANES))); // R7

  AST_BAD_ZERO: assert property (@(posedge clk) disable iff (!rst_q)
    (res_vld && res_bad) |-> (res_degree == '0)); // R10

endmodule

// File: rtl/swz_bank_unit.sv
module swz_bank_unit
  import swz_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int LANES      = 8,
  parameter int ATOM_LEN   = 3,
  parameter int BANK_BYTES = 4,
  parameter int NBANK      = 32,
  localparam int WORD_LSB  = $clog2(BANK_BYTES),
  localparam int BANK_W    = $clog2(NBANK),
  localparam int LINE_W    = ADDR_W + 2 - WORD_LSB - BANK_W,
  localparam int WORD_W    = ADDR_W + 2 - WORD_LSB,
  localparam int CNT_W     = $clog2(LANES + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              in_dtype,
  input  logic [1:0]              in_mode,
  input  logic                    in_vld,
  input  logic [ADDR_W-1:0]       in_addr,
  output logic                    out_vld,
  output logic [ADDR_W-1:0]       out_addr,
  output logic [BANK_W-1:0]       out_bank,
  output logic [LINE_W-1:0]       out_line,
  output logic                    out_err,
  input  logic                    grp_vld,
  input  logic [LANES*ADDR_W-1:0] grp_addr,
  output logic                    cnf_vld,
  output logic [CNT_W-1:0]        cnf_degree,
  output logic                    cnf_err
);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta;
  logic rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  swz_cfg_t cfg;

  swz_param_decode #(.ATOM_LEN(ATOM_LEN)) u_decode (
    .esz_code  (in_dtype),
    .mode_code (in_mode),
    .cfg       (cfg)
  );

  // ---------------- single-address path, stage 1: permute ----------------
  logic [ADDR_W-1:0] perm_addr;
  logic [ADDR_W-1:0] s1_addr_d;
  logic              s1_vld;
  logic [ADDR_W-1:0] s1_addr;
  logic [1:0]        s1_bsh;
  logic              s1_bad;

  swz_permute #(.ADDR_W(ADDR_W), .ATOM_LEN(ATOM_LEN)) u_perm (
    .lin_addr (in_addr),
    .keep_w   (cfg.keep_w),
    .fold_w   (cfg.fold_w),
    .swz_addr (perm_addr)
  );

  always_comb begin
    s1_addr_d = cfg.bad ? '0 : perm_addr;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      s1_vld <= 1'b0;
    end else begin
      s1_vld <= in_vld;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      s1_addr <= '0;
      s1_bsh  <= '0;
      s1_bad  <= 1'b0;
    end else if (in_vld) begin
      s1_addr <= s1_addr_d;
      s1_bsh  <= cfg.byte_sh;
      s1_bad  <= cfg.bad;
    end
  end

  // ---------------- stage 2: bank and line ----------------
  logic [BANK_W-1:0] bank_d;
  logic [LINE_W-1:0] line_d;
  logic [BANK_W-1:0] bank_q;
  logic [LINE_W-1:0] line_q;

  swz_bank_calc #(.ADDR_W(ADDR_W), .BANK_BYTES(BANK_BYTES), .NBANK(NBANK)) u_bank (
    .elem_addr (s1_addr),
    .byte_sh   (s1_bsh),
    .bank      (bank_d),
    .line      (line_d)
  );

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      out_vld <= 1'b0;
    end else begin
      out_vld <= s1_vld;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      out_addr <= '0;
      bank_q   <= '0;
      line_q   <= '0;
      out_err  <= 1'b0;
    end else if (s1_vld) begin
      out_addr <= s1_addr;
      bank_q   <= s1_bad ? '0 : bank_d;
      line_q   <= s1_bad ? '0 : line_d;
      out_err  <= s1_bad;
    end
  end

  assign out_bank = bank_q;
  assign out_line = line_q;

  // ---------------- group path: per-lane swizzle and word ----------------
  logic [WORD_W-1:0] lane_word [LANES];

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [ADDR_W-1:0] lane_swz;
    logic [ADDR_W+1:0] lane_byte;

    swz_permute #(.ADDR_W(ADDR_W), .ATOM_LEN(ATOM_LEN)) u_lane_perm (
      .lin_addr (grp_addr[k*ADDR_W +: ADDR_W]),
      .keep_w   (cfg.keep_w),
      .fold_w   (cfg.fold_w),
      .swz_addr (lane_swz)
    );

    always_comb begin
      lane_byte    = {2'b00, lane_swz} << cfg.byte_sh;
      lane_word[k] = WORD_W'(lane_byte >> WORD_LSB);
    end
  end

  swz_conflict_count #(.LANES(LANES), .WORD_W(WORD_W), .BANK_W(BANK_W)) u_conflict (
    .clk        (clk),
    .rst_q      (rst_q),
    .req_vld    (grp_vld),
    .req_bad    (cfg.bad),
    .word       (lane_word),
    .res_vld    (cnf_vld),
    .res_degree (cnf_degree),
    .res_bad    (cnf_err)
  );

  // ---------------- assertions ----------------
  AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (!rst_q)
    in_vld |-> ##2 out_vld); // R5

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_q)
    !in_vld |-> ##2 !out_vld); // R5

  AST_NONE_IDENTITY: assert property (@(posedge clk) disable iff (!rst_q)
    (in_vld && in_mode == 2'd0 && in_dtype != 2'd3) |-> ##2 (out_addr == $past(in_addr, 2))); // R3

  AST_LOW_KEPT: assert property (@(posedge clk) disable iff (!rst_q)
    (in_vld && in_dtype != 2'd3) |-> ##2 (out_addr[1:0] == $past(in_addr[1:0], 2))); // R2

  AST_ERR_ZEROES: assert property (@(posedge clk) disable iff (!rst_q)
    (out_vld && out_err) |-> (out_addr == '0 && out_bank == '0 && out_line == '0)); // R6

  AST_CNF_LATENCY: assert property (@(posedge clk) disable iff (!rst_q)
    grp_vld |=> cnf_vld); // R7

endmodule

// File: tb/test_swz_bank_unit.sv
`timescale 1ns/1ps
module test_swz_bank_unit;

  localparam int ADDR_W = 16;
  localparam int LANES  = 8;

  logic                    clk = 1'b0;
  logic                    rst_n;
  logic [1:0]              in_dtype;
  logic [1:0]              in_mode;
  logic                    in_vld;
  logic [ADDR_W-1:0]       in_addr;
  logic                    out_vld;
  logic [ADDR_W-1:0]       out_addr;
  logic [4:0]              out_bank;
  logic [10:0]             out_line;
  logic                    out_err;
  logic                    grp_vld;
  logic [LANES*ADDR_W-1:0] grp_addr;
  logic                    cnf_vld;
  logic [3:0]              cnf_degree;
  logic                    cnf_err;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  swz_bank_unit i_swz_bank_unit (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_dtype   (in_dtype),
    .in_mode    (in_mode),
    .in_vld     (in_vld),
    .in_addr    (in_addr),
    .out_vld    (out_vld),
    .out_addr   (out_addr),
    .out_bank   (out_bank),
    .out_line   (out_line),
    .out_err    (out_err),
    .grp_vld    (grp_vld),
    .grp_addr   (grp_addr),
    .cnf_vld    (cnf_vld),
    .cnf_degree (cnf_degree),
    .cnf_err    (cnf_err)
  );

  // {addr, dtype, mode, exp_addr, exp_bank, exp_line, exp_err}
  localparam int VW = 53;
  localparam int NV = 10;
  localparam logic [VW-1:0] VEC [NV] = '{
    {16'd64,     2'd1, 2'd3, 16'd72,     5'd4,  11'd1,    1'b0},
    {16'd448,    2'd1, 2'd3, 16'd504,    5'd28, 11'd7,    1'b0},
    {16'd448,    2'd1, 2'd0, 16'd448,    5'd0,  11'd7,    1'b0},
    {16'd128,    2'd0, 2'd1, 16'd144,    5'd4,  11'd1,    1'b0},
    {16'd96,     2'd2, 2'd2, 16'd108,    5'd12, 11'd3,    1'b0},
    {16'd229,    2'd2, 2'd3, 16'd249,    5'd25, 11'd7,    1'b0},
    {16'hFFFF,   2'd1, 2'd3, 16'hFFC7,   5'd3,  11'd1023, 1'b0},
    {16'h1234,   2'd3, 2'd2, 16'd0,      5'd0,  11'd0,    1'b1},
    {16'd263,    2'd0, 2'd0, 16'd263,    5'd1,  11'd2,    1'b0},
    {16'd192,    2'd1, 2'd1, 16'd200,    5'd4,  11'd3,    1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic single(input logic [15:0] a, input logic [1:0] dt, input logic [1:0] md);
    @(negedge clk);
    in_addr  = a;
    in_dtype = dt;
    in_mode  = md;
    in_vld   = 1'b1;
    @(negedge clk);
    in_vld = 1'b0;
    check("R5 out_vld one cycle after strobe", {31'd0, out_vld}, 32'd0);
    @(negedge clk);
    check("R5 out_vld two cycles after strobe", {31'd0, out_vld}, 32'd1);
  endtask

  task automatic group(input logic [LANES*ADDR_W-1:0] ga, input logic [1:0] dt,
                       input logic [1:0] md);
    @(negedge clk);
    grp_addr = ga;
    in_dtype = dt;
    in_mode  = md;
    grp_vld  = 1'b1;
    @(negedge clk);
    grp_vld = 1'b0;
    check("R7 cnf_vld one cycle after strobe", {31'd0, cnf_vld}, 32'd1);
  endtask

  function automatic logic [LANES*ADDR_W-1:0] column(input int j);
    logic [LANES*ADDR_W-1:0] g;
    for (int i = 0; i < LANES; i++) g[i*ADDR_W +: ADDR_W] = 16'(64 * i + j);
    return g;
  endfunction

  initial begin
    logic [LANES*ADDR_W-1:0] ga;
    rst_n    = 1'b0;
    in_dtype = 2'd0;
    in_mode  = 2'd0;
    in_vld   = 1'b0;
    in_addr  = '0;
    grp_vld  = 1'b0;
    grp_addr = '0;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 out_vld in reset", {31'd0, out_vld}, 32'd0);
    check("R9 cnf_vld in reset", {31'd0, cnf_vld}, 32'd0);
    check("R9 out_addr in reset", {16'd0, out_addr}, 32'd0);
    check("R9 cnf_degree in reset", {28'd0, cnf_degree}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R9 out_vld after reset", {31'd0, out_vld}, 32'd0);

    // table walk: R1 R2 R3 R4 R6
    for (int v = 0; v < NV; v++) begin
      single(VEC[v][52:37], VEC[v][36:35], VEC[v][34:33]);
      check("R1 R2 R3 swizzled address", {16'd0, out_addr}, {16'd0, VEC[v][32:17]});
      check("R4 bank", {27'd0, out_bank}, {27'd0, VEC[v][16:12]});
      check("R4 line", {21'd0, out_line}, {21'd0, VEC[v][11:1]});
      check("R6 error flag", {31'd0, out_err}, {31'd0, VEC[v][0]});
    end

    // R5: idle cycles give no result
    repeat (3) @(negedge clk);
    check("R5 no result without strobe", {31'd0, out_vld}, 32'd0);

    // R8: column 0 of an 8x64 fp16 tile, 128B mode -> banks 0,4,...,28
    for (int i = 0; i < LANES; i++) begin
      single(16'(64 * i), 2'd1, 2'd3);
      check("R8 column bank under 128B", {27'd0, out_bank}, 32'(4 * i));
    end
    group(column(0), 2'd1, 2'd3);
    check("R8 degree under 128B", {28'd0, cnf_degree}, 32'd1);
    group(column(0), 2'd1, 2'd0);
    check("R8 degree without swizzle", {28'd0, cnf_degree}, 32'd8);

    // R7: repeated words count once; bank 0 holds three words here
    ga = '0;
    ga[0*16 +: 16] = 16'd0;   ga[1*16 +: 16] = 16'd1;
    ga[2*16 +: 16] = 16'd2;   ga[3*16 +: 16] = 16'd3;
    ga[4*16 +: 16] = 16'd128; ga[5*16 +: 16] = 16'd256;
    ga[6*16 +: 16] = 16'd4;   ga[7*16 +: 16] = 16'd8;
    group(ga, 2'd0, 2'd0);
    check("R7 degree with repeated words", {28'd0, cnf_degree}, 32'd3);
    check("R7 no error on valid group", {31'd0, cnf_err}, 32'd0);

    // R7: all lanes on one word
    group('0, 2'd2, 2'd1);
    check("R7 single word degree", {28'd0, cnf_degree}, 32'd1);

    // R10: invalid size on group path
    group(column(0), 2'd3, 2'd0);
    check("R10 group error flag", {31'd0, cnf_err}, 32'd1);
    check("R10 group degree zero", {28'd0, cnf_degree}, 32'd0);

    // R9: reset mid-run clears outputs
    single(16'd448, 2'd1, 2'd3);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R9 out_vld after re-reset", {31'd0, out_vld}, 32'd0);
    check("R9 out_addr after re-reset", {16'd0, out_addr}, 32'd0);
    check("R9 out_bank after re-reset", {27'd0, out_bank}, 32'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule